// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Condition Flags

This block is the combinational execution core of a small 16-bit processor. Each cycle it takes a source operand, a destination operand, an operation code and a flag that marks the source as a short quick immediate. It returns the 16-bit result, a write-back enable and four condition flags: zero, negative, unsigned overflow and signed overflow. The surrounding pipeline fetches the operands, stores the flags and writes the result back. This block only computes.

The operations are pass-through (used for moves and loads), bitwise AND, OR and XOR, logical shifts left and right, add, subtract and compare. Bitwise inversion is XOR with all ones. When the quick flag is set, only the low four bits of the source are used. They are widened to 16 bits by sign extension or by zero extension, and the operation code decides which. The block has no state and no clock.

Top module: `alu16`

## Requirements
- R1: Operation code 0 (pass) drives the result with the selected source operand and asserts write-back. Both overflow flags are clear.
- R2: With the quick flag set, operation codes 0, 1, 2, 3 and 8 (pass, AND, OR, XOR, compare) sign-extend source bits [3:0] to 16 bits. Source bits [15:4] are ignored.
- R3: With the quick flag set, operation codes 4, 5, 6 and 7 (shift left, shift right, add, subtract) zero-extend source bits [3:0] to 16 bits. Source bits [15:4] are ignored.
- R4: Codes 1, 2 and 3 give the destination ANDed, ORed and XORed with the source. XOR with 0xFFFF yields the bitwise inverse of the destination.
- R5: Codes 4 and 5 shift the destination logically left and right, filling with zeros. The shift count is bits [3:0] of the source (0 to 15) and all higher source bits are ignored.
- R6: Codes 1 to 5 always clear both the unsigned and the signed overflow flag.
- R7: Code 6 adds destination and source. Unsigned overflow is the carry out of bit 15. Signed overflow is set when two operands of equal sign give a result of the other sign.
- R8: Code 7 yields destination minus source. Unsigned overflow is set when source > destination as unsigned values (borrow). Signed overflow is set when operands of different sign give a result whose sign differs from the destination.
- R9: Code 8 (compare) produces the same result and flags as code 7 but deasserts write-back.
- R10: For every defined code, zero is set exactly when the 16-bit result is 0x0000, and negative is set exactly when result bit 15 is one.
- R11: Codes 9 to 15 are undefined. They drive a zero result, deassert write-back and clear all four flags.
- R12: Codes 0 to 7 assert write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand, or quick immediate in bits [3:0] |
| dst_i | input | 16 | Destination operand |
| op_i | input | 4 | Operation code (0 pass, 1 AND, 2 OR, 3 XOR, 4 shift left, 5 shift right, 6 add, 7 subtract, 8 compare) |
| quick_i | input | 1 | Source is a four-bit quick immediate |
| result_o | output | 16 | Operation result |
| wr_en_o | output | 1 | Result is to be written back |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_u_o | output | 1 | Unsigned overflow flag |
| flag_s_o | output | 1 | Signed overflow flag |

## Verification
A vector table drives each operation with operand pairs chosen to separate the flag rules. These pairs include a carry without signed overflow, a signed overflow without carry, both at once, a borrow, and a compare of the most negative value against the most positive. Quick vectors keep garbage in source bits [15:4] and use nibbles with bit 3 set, so a wrong extension mode or a leak of upper bits changes the result. Sweeps over all sixteen shift counts and all sixteen quick nibbles catch an off-by-one stage in the shifter and a mixed-up extension table. A sweep of the seven undefined codes confirms that they stay silent.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned QUICK_W = 4;
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_XOR  = 4'd3,
        OP_SHL  = 4'd4,
        OP_SHR  = 4'd5,
        OP_ADD  = 4'd6,
        OP_SUB  = 4'd7,
        OP_CMP  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic uovf;
        logic sovf;
    } alu_flags_t;

    // Decoded control for one operation.
    typedef struct packed {
        logic valid;       // defined operation code
        logic quick_sign;  // quick immediate is sign-extended
        logic use_arith;   // result taken from the adder
        logic use_logic;   // result taken from the logic/shift unit
        logic subtract;    // adder computes dst - src
        logic keep_ovf;    // overflow flags come from the adder
        logic write_back;  // result is written back
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c = '0;
        case (code)
            OP_PASS: begin
                c.valid = 1'b1; c.quick_sign = 1'b1; c.write_back = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                c.valid = 1'b1; c.quick_sign = 1'b1; c.use_logic = 1'b1;
                c.write_back = 1'b1;
            end
            OP_SHL, OP_SHR: begin
                c.valid = 1'b1; c.use_logic = 1'b1; c.write_back = 1'b1;
            end
            OP_ADD: begin
                c.valid = 1'b1; c.use_arith = 1'b1; c.keep_ovf = 1'b1;
                c.write_back = 1'b1;
            end
            OP_SUB: begin
                c.valid = 1'b1; c.use_arith = 1'b1; c.subtract = 1'b1;
                c.keep_ovf = 1'b1; c.write_back = 1'b1;
            end
            OP_CMP: begin
                c.valid = 1'b1; c.quick_sign = 1'b1; c.use_arith = 1'b1;
                c.subtract = 1'b1; c.keep_ovf = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu16_quick_ext.sv
module alu16_quick_ext #(
    parameter int unsigned W  = 16,
    parameter int unsigned QW = 4
) (
    input  logic [QW-1:0] nib_i,
    input  logic          sign_i,
    output logic [W-1:0]  ext_o
);
    localparam int unsigned PAD = W - QW;

    logic fill;
    assign fill  = sign_i & nib_i[QW-1];
    assign ext_o = {{PAD{fill}}, nib_i};
endmodule

// File: rtl/alu16_logic_unit.sv
module alu16_logic_unit
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]    src_i,
    input  logic [W-1:0]    dst_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o
);
    localparam int unsigned SW = $clog2(W);

    logic [W-1:0] left_stage  [SW+1];
    logic [W-1:0] right_stage [SW+1];

    assign left_stage[0]  = dst_i;
    assign right_stage[0] = dst_i;

    // Barrel shifter: stage g moves by 2**g when count bit g is set.
    for (genvar g = 0; g < SW; g++) begin : g_stage
        localparam int unsigned STEP = 1 << g;
        assign left_stage[g+1]  = src_i[g] ? {left_stage[g][W-1-STEP:0], {STEP{1'b0}}}
                                           : left_stage[g];
        assign right_stage[g+1] = src_i[g] ? {{STEP{1'b0}}, right_stage[g][W-1:STEP]}
                                           : right_stage[g];
    end

    always_comb begin
        case (op_i)
            OP_AND:  res_o = dst_i & src_i;
            OP_OR:   res_o = dst_i | src_i;
            OP_XOR:  res_o = dst_i ^ src_i;
            OP_SHL:  res_o = left_stage[SW];
            OP_SHR:  res_o = right_stage[SW];
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu16_arith_unit.sv
module alu16_arith_unit #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic         subtract_i,
    output logic [W-1:0] sum_o,
    output logic         uovf_o,
    output logic         sovf_o
);
    logic [W:0] wide;
    logic       s_src, s_dst, s_res;

    always_comb begin
        if (subtract_i) wide = {1'b0, dst_i} - {1'b0, src_i};
        else            wide = {1'b0, dst_i} + {1'b0, src_i};
    end

    assign sum_o  = wide[W-1:0];
    assign uovf_o = wide[W];   // carry on add, borrow on subtract

    assign s_src = src_i[W-1];
    assign s_dst = dst_i[W-1];
    assign s_res = wide[W-1];

    always_comb begin
        if (subtract_i) sovf_o = (s_dst != s_src) && (s_res != s_dst);
        else            sovf_o = (s_dst == s_src) && (s_res != s_dst);
    end
endmodule

// File: rtl/alu16_flag_gen.sv
module alu16_flag_gen
    import alu16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] res_i,
    input  logic         valid_i,
    input  logic         keep_ovf_i,
    input  logic         uovf_i,
    input  logic         sovf_i,
    output alu_flags_t   flags_o
);
    always_comb begin
        flags_o.zero = valid_i & (res_i == '0);
        flags_o.neg  = valid_i & res_i[W-1];
        flags_o.uovf = valid_i & keep_ovf_i & uovf_i;
        flags_o.sovf = valid_i & keep_ovf_i & sovf_i;
    end
endmodule

// File: rtl/alu16.sv
module alu16
    import alu16_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned QW = QUICK_W
) (
    input  logic [W-1:0]    src_i,
    input  logic [W-1:0]    dst_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            quick_i,
    output logic [W-1:0]    result_o,
    output logic            wr_en_o,
    output logic            flag_z_o,
    output logic            flag_n_o,
    output logic            flag_u_o,
    output logic            flag_s_o
);
    alu_ctrl_t    ctrl;
    alu_flags_t   flags;
    logic [W-1:0] quick_val;
    logic [W-1:0] operand;
    logic [W-1:0] logic_res;
    logic [W-1:0] arith_res;
    logic [W-1:0] result;
    logic         arith_u, arith_s;

    assign ctrl = decode_op(op_i);

    alu16_quick_ext #(.W(W), .QW(QW)) i_quick (
        .nib_i  (src_i[QW-1:0]),
        .sign_i (ctrl.quick_sign),
        .ext_o  (quick_val)
    );

    assign operand = quick_i ? quick_val : src_i;

    alu16_logic_unit #(.W(W)) i_logic (
        .src_i (operand),
        .dst_i (dst_i),
        .op_i  (op_i),
        .res_o (logic_res)
    );

    alu16_arith_unit #(.W(W)) i_arith (
        .src_i      (operand),
        .dst_i      (dst_i),
        .subtract_i (ctrl.subtract),
        .sum_o      (arith_res),
        .uovf_o     (arith_u),
        .sovf_o     (arith_s)
    );

    always_comb begin
        if (!ctrl.valid)         result = '0;
        else if (ctrl.use_arith) result = arith_res;
        else if (ctrl.use_logic) result = logic_res;
        else                     result = operand;
    end

    alu16_flag_gen #(.W(W)) i_flags (
        .res_i      (result),
        .valid_i    (ctrl.valid),
        .keep_ovf_i (ctrl.keep_ovf),
        .uovf_i     (arith_u),
        .sovf_i     (arith_s),
        .flags_o    (flags)
    );

    assign result_o = result;
    assign wr_en_o  = ctrl.write_back;
    assign flag_z_o = flags.zero;
    assign flag_n_o = flags.neg;
    assign flag_u_o = flags.uovf;
    assign flag_s_o = flags.sovf;
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker
    import alu16_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned QW = QUICK_W
) (
    input logic [W-1:0]    src_i,
    input logic [W-1:0]    dst_i,
    input logic [OP_W-1:0] op_i,
    input logic            quick_i,
    input logic [W-1:0]    result_o,
    input logic            wr_en_o,
    input logic            flag_z_o,
    input logic            flag_n_o,
    input logic            flag_u_o,
    input logic            flag_s_o
);
    localparam int unsigned SW = $clog2(W);

    always_comb begin
        // R6: logic and shift codes never report overflow
        if (op_i >= 4'd1 && op_i <= 4'd5)
            a_r6_no_overflow: assert (!flag_u_o && !flag_s_o);
        // R9: compare never writes back
        if (op_i == 4'd8)
            a_r9_cmp_no_write: assert (!wr_en_o);
        // R7: plain add result matches operand sum
        if (op_i == 4'd6 && !quick_i)
            a_r7_add_sum: assert (result_o == W'(src_i + dst_i));
        // R8: plain subtract borrow tracks operand order
        if (op_i == 4'd7 && !quick_i)
            a_r8_sub_borrow: assert (flag_u_o == (src_i > dst_i));
        // R5: plain shift left uses only the low count bits
        if (op_i == 4'd4 && !quick_i)
            a_r5_shl_count: assert (result_o == (dst_i << src_i[SW-1:0]));
        // R11: undefined codes are silent
        if (op_i > 4'd8)
            a_r11_undef_quiet: assert (result_o == '0 && !wr_en_o && !flag_z_o
                                       && !flag_n_o && !flag_u_o && !flag_s_o);
        // R2: quick pass sign-extends the nibble
        if (op_i == 4'd0 && quick_i)
            a_r2_quick_sign: assert (result_o == {{(W-QW){src_i[QW-1]}}, src_i[QW-1:0]});
    end
endmodule

bind alu16 alu16_checker #(.W(W), .QW(QW)) i_alu16_checker (.*);

// File: tb/test_alu16.sv
module test_alu16;
    localparam int unsigned NVEC = 27;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src, dst;
    logic [3:0]  op;
    logic        quick;
    logic [15:0] result;
    logic        wr_en, fz, fn, fu, fs;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;

    alu16 i_alu16 (
        .src_i    (src),
        .dst_i    (dst),
        .op_i     (op),
        .quick_i  (quick),
        .result_o (result),
        .wr_en_o  (wr_en),
        .flag_z_o (fz),
        .flag_n_o (fn),
        .flag_u_o (fu),
        .flag_s_o (fs)
    );

    // {op, quick, src, dst, result, wr_en, flags z n u s}
    localparam logic [57:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 16'h1234, 16'h5555, 16'h1234, 1'b1, 4'b0000},
        {4'd0, 1'b0, 16'h8000, 16'h0000, 16'h8000, 1'b1, 4'b0100},
        {4'd0, 1'b1, 16'hAB0F, 16'h0000, 16'hFFFF, 1'b1, 4'b0100},
        {4'd0, 1'b1, 16'hFFF7, 16'h0000, 16'h0007, 1'b1, 4'b0000},
        {4'd0, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 4'b1000},
        {4'd1, 1'b0, 16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 4'b0100},
        {4'd2, 1'b0, 16'h000F, 16'h00F0, 16'h00FF, 1'b1, 4'b0000},
        {4'd3, 1'b0, 16'hFFFF, 16'h1234, 16'hEDCB, 1'b1, 4'b0100},
        {4'd3, 1'b1, 16'h120F, 16'h1234, 16'hEDCB, 1'b1, 4'b0100},
        {4'd1, 1'b1, 16'h0008, 16'h00FF, 16'h00F8, 1'b1, 4'b0000},
        {4'd4, 1'b0, 16'h0013, 16'h1001, 16'h8008, 1'b1, 4'b0100},
        {4'd5, 1'b0, 16'hFFF4, 16'h8000, 16'h0800, 1'b1, 4'b0000},
        {4'd4, 1'b0, 16'h0010, 16'h8000, 16'h8000, 1'b1, 4'b0100},
        {4'd5, 1'b0, 16'h000F, 16'h8000, 16'h0001, 1'b1, 4'b0000},
        {4'd4, 1'b0, 16'h000F, 16'h0003, 16'h8000, 1'b1, 4'b0100},
        {4'd6, 1'b0, 16'h0001, 16'hFFFF, 16'h0000, 1'b1, 4'b1010},
        {4'd6, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b1, 4'b0101},
        {4'd6, 1'b1, 16'hFF0F, 16'h0001, 16'h0010, 1'b1, 4'b0000},
        {4'd6, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'b1011},
        {4'd7, 1'b0, 16'h0001, 16'h0000, 16'hFFFF, 1'b1, 4'b0110},
        {4'd7, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'b0001},
        {4'd7, 1'b1, 16'h000F, 16'h0020, 16'h0011, 1'b1, 4'b0000},
        {4'd8, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b0, 4'b1000},
        {4'd8, 1'b1, 16'h000F, 16'h0000, 16'h0001, 1'b0, 4'b0010},
        {4'd8, 1'b0, 16'h7FFF, 16'h8000, 16'h0001, 1'b0, 4'b0001},
        {4'd9, 1'b0, 16'h1234, 16'h0000, 16'h0000, 1'b0, 4'b0000},
        {4'd7, 1'b1, 16'h00F0, 16'h0005, 16'h0005, 1'b1, 4'b0000}
    };

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0:                return "R1";
            4'd1, 4'd2, 4'd3:    return "R4";
            4'd4, 4'd5:          return "R5";
            4'd6:                return "R7";
            4'd7:                return "R8";
            4'd8:                return "R9";
            default:             return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] exp_res,
                         input logic exp_wr, input logic [3:0] exp_fl);
        logic [3:0] got_fl;
        got_fl = {fz, fn, fu, fs};
        n_checks++;
        if (result !== exp_res || wr_en !== exp_wr || got_fl !== exp_fl) begin
            n_fail++;
            $display("FAIL %s op=%0d q=%0b src=%h dst=%h: got res=%h wr=%b zn_us=%b, expected res=%h wr=%b zn_us=%b",
                     req, op, quick, src, dst, result, wr_en, got_fl,
                     exp_res, exp_wr, exp_fl);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic q,
                         input logic [15:0] s, input logic [15:0] d);
        @(posedge clk);
        op = o; quick = q; src = s; dst = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        src = '0; dst = '0; op = '0; quick = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1, R10, R12: idle inputs (pass of zero) give zero result, zero flag
        check("R1", 16'h0000, 1'b1, 4'b1000);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][57:54], VEC[i][53], VEC[i][52:37], VEC[i][36:21]);
            check(req_of(VEC[i][57:54]), VEC[i][20:5], VEC[i][4], VEC[i][3:0]);
        end

        // R5, R6, R10: every shift count, with garbage in upper count bits
        for (int k = 0; k < 16; k++) begin
            logic [15:0] d, e;
            d = 16'hA5C3;
            e = d << k;
            apply(4'd4, 1'b0, {12'hABC, 4'(k)}, d);
            check("R5", e, 1'b1, {e == 16'h0, e[15], 2'b00});
            e = d >> k;
            apply(4'd5, 1'b0, {12'h5E1, 4'(k)}, d);
            check("R6", e, 1'b1, {e == 16'h0, e[15], 2'b00});
        end

        // R2 and R3: every quick nibble under both extension modes
        for (int k = 0; k < 16; k++) begin
            logic [3:0]  nib;
            logic [15:0] e;
            nib = 4'(k);
            e = {{12{nib[3]}}, nib};
            apply(4'd0, 1'b1, {12'h9A6, nib}, 16'h0000);
            check("R2", e, 1'b1, {e == 16'h0, e[15], 2'b00});
            e = {12'h000, nib};
            apply(4'd6, 1'b1, {12'h9A6, nib}, 16'h0000);
            check("R3", e, 1'b1, {e == 16'h0, 1'b0, 2'b00});
        end

        // R11: undefined codes stay silent
        for (int c = 9; c < 16; c++) begin
            apply(4'(c), 1'b0, 16'hFFFF, 16'h0001);
            check("R11", 16'h0000, 1'b0, 4'b0000);
        end

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout, expected completion");
        finish_run();
    end
endmodule